// File: doc/BRIEF.md
# Predicated Execute Stage with Compare Flags

This block is the execute stage of a small load-store register machine. Each instruction it receives carries a condition code, and every operation (add, subtract, compare, conditional branch) is carried out only when that condition holds against a stored flag state. A compare of two operands sets the flag state to exactly one of three values: equal, less than or greater than. Later add and subtract operations raise the register write enable only when their condition holds. A conditional branch asserts the branch-taken output only when its condition holds.

Before the adder, the second operand passes through an inline left shifter. The shift amount can be anything from zero up to one less than the data width, and bits shifted out are dropped. Operands come from an external register file of `NREGS` entries, and the result goes back to it through the destination index and write enable. The flag state is the state machine of the block, with three states: `FL_EQ` (the reset state), `FL_LT` and `FL_GT`. The only transition is an executed compare, which moves the machine to the state given by the unsigned comparison `in_a` against the shifted `in_b`. Every other input leaves the state where it is.

Each instruction accepted on a rising edge with `in_valid` high appears on the outputs after that same edge and stays there for one cycle. An instruction accepted on one edge sees the flags written by a compare accepted on the edge before it. The stage can therefore run compare, subtract-if-greater, subtract-if-less-or-equal and branch-if-not-equal back to back to compute a greatest common divisor without any other branch.

Top module: `pred_exec_stage`

## Requirements
- R1: After reset the flag state is equal, and `res_wen` and `br_taken` are low.
- R2: An executed compare (`in_op`=3) sets the flags to exactly one of equal, less than or greater than, from an unsigned comparison of `in_a` with the shifted `in_b`. A compare never writes a register and never branches.
- R3: Condition codes on `in_cc` are 1 equal, 2 not equal, 3 greater, 4 less, 5 greater-or-equal (not less) and 6 less-or-equal (not greater). A subtract tagged 3 writes only on greater, and one tagged 6 writes on equal or less.
- R4: Code 0 executes whatever the flags hold. Code 7 never executes.
- R5: When the condition fails, `res_wen` and `br_taken` stay low and the flags keep their value, including for a compare.
- R6: An add (`in_op`=1) produces `in_a + (in_b << in_shamt)` modulo 2^W, for shift amounts 0 to W-1, with the shifted-out bits dropped.
- R7: A subtract (`in_op`=2) produces `in_a - (in_b << in_shamt)` modulo 2^W and writes `res_dst` = `in_dst`.
- R8: A branch (`in_op`=4) asserts `br_taken` when its condition holds and never writes. A branch tagged not-equal is taken whenever the flags are not equal.
- R9: Outputs appear one clock edge after the instruction is accepted. With `in_valid` low, or with op 0, nothing is written, no branch is taken and the flags hold.
- R10: Add, subtract and branch leave the flags unchanged.
- R11: The four-instruction sequence compare, subtract-if-greater, subtract-if-less-or-equal, branch-if-not-equal, repeated while the branch is taken, leaves the greatest common divisor in the first operand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation: 0 none, 1 add, 2 subtract, 3 compare, 4 branch |
| in_cc | input | 3 | Condition code (see R3, R4) |
| in_a | input | W | First register operand |
| in_b | input | W | Second register operand, before shifting |
| in_shamt | input | clog2(W) | Left shift applied to `in_b` |
| in_dst | input | clog2(NREGS) | Destination register index |
| res_data | output | W | Add or subtract result |
| res_dst | output | clog2(NREGS) | Destination index for the write |
| res_wen | output | 1 | Register write enable |
| br_taken | output | 1 | Conditional branch taken |

## Verification
The bench goes after several corner cases. One is a compare whose operands differ in the top bit: a design that compares signed would take the greater-than path as less-than. Another is a compare tagged with a failing condition: a design that updates the flags anyway would let a later greater-than subtract go silent. The bench also uses shift amounts of zero and W-1 and an unsigned subtract underflow, where a shifter with a wrong stage order or a carry left in place would return the wrong sum. Finally, it checks that a branch or an arithmetic operation that overwrites the flags, or a not-equal branch that decodes the wrong flag, breaks the greatest common divisor loop on equal and coprime inputs.

// File: rtl/pex_pkg.sv
package pex_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_CMP = 3'd3,
        OP_BRC = 3'd4
    } pex_op_e;

    typedef enum logic [2:0] {
        CC_AL = 3'd0,
        CC_EQ = 3'd1,
        CC_NE = 3'd2,
        CC_GT = 3'd3,
        CC_LT = 3'd4,
        CC_GE = 3'd5,
        CC_LE = 3'd6,
        CC_NV = 3'd7
    } pex_cc_e;

    typedef enum logic [1:0] {
        FL_EQ = 2'd0,
        FL_LT = 2'd1,
        FL_GT = 2'd2
    } pex_flag_e;

endpackage

// File: rtl/pex_lshift.sv
module pex_lshift #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        assign stg[i+1] = amt[i] ? (stg[i] << (1 << i)) : stg[i];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/pex_alu.sv
module pex_alu
    import pex_pkg::*;
#(
    parameter int W = 32
) (
    input  pex_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  res,
    output pex_flag_e     cmp
);
    always_comb begin
        unique case (op)
            OP_SUB:  res = a - b;
            default: res = a + b;
        endcase
    end

    always_comb begin
        if (a == b)     cmp = FL_EQ;
        else if (a < b) cmp = FL_LT;
        else            cmp = FL_GT;
    end
endmodule

// File: rtl/pex_cond_eval.sv
module pex_cond_eval
    import pex_pkg::*;
(
    input  logic [2:0] cc,
    input  pex_flag_e  flag,
    output logic       pass
);
    pex_cc_e code;
    assign code = pex_cc_e'(cc);

    always_comb begin
        unique case (code)
            CC_AL: pass = 1'b1;
            CC_EQ: pass = (flag == FL_EQ);
            CC_NE: pass = (flag != FL_EQ);
            CC_GT: pass = (flag == FL_GT);
            CC_LT: pass = (flag == FL_LT);
            CC_GE: pass = (flag != FL_LT);
            CC_LE: pass = (flag != FL_GT);
            CC_NV: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/pred_exec_stage.sv
module pred_exec_stage
    import pex_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREGS = 16,
    localparam int SW   = $clog2(W),
    localparam int RW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [2:0]    in_cc,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [SW-1:0] in_shamt,
    input  logic [RW-1:0] in_dst,
    output logic [W-1:0]  res_data,
    output logic [RW-1:0] res_dst,
    output logic          res_wen,
    output logic          br_taken
);
    pex_op_e      op;
    pex_flag_e    flag_q, flag_d, cmp_flag;
    logic [W-1:0] b_sh, alu_res;
    logic         cc_ok, fire;

    assign op   = pex_op_e'(in_op);
    assign fire = in_valid && cc_ok;

    pex_lshift #(.W(W), .SW(SW)) u_shift (
        .din  (in_b),
        .amt  (in_shamt),
        .dout (b_sh)
    );

    pex_alu #(.W(W)) u_alu (
        .op  (op),
        .a   (in_a),
        .b   (b_sh),
        .res (alu_res),
        .cmp (cmp_flag)
    );

    pex_cond_eval u_cc (
        .cc   (in_cc),
        .flag (flag_q),
        .pass (cc_ok)
    );

    // Next flag state: only an executed compare moves the machine.
    always_comb begin
        flag_d = flag_q;
        if (fire && op == OP_CMP) begin
            unique case (cmp_flag)
                FL_LT:   flag_d = FL_LT;
                FL_GT:   flag_d = FL_GT;
                default: flag_d = FL_EQ;
            endcase
        end
    end

    // Flag state register
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= FL_EQ;
        else        flag_q <= flag_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_dst  <= '0;
            res_wen  <= 1'b0;
            br_taken <= 1'b0;
        end else begin
            res_data <= alu_res;
            res_dst  <= in_dst;
            unique case (op)
                OP_ADD, OP_SUB: begin
                    res_wen  <= fire;
                    br_taken <= 1'b0;
                end
                OP_BRC: begin
                    res_wen  <= 1'b0;
                    br_taken <= fire;
                end
                default: begin
                    res_wen  <= 1'b0;
                    br_taken <= 1'b0;
                end
            endcase
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |-> (!res_wen && !br_taken));

    // R5
    false_cc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cc_ok)) |-> (!res_wen && !br_taken && flag_q == $past(flag_q)));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op) != OP_CMP) |-> (flag_q == $past(flag_q)));

    // R8
    branch_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> !res_wen);
endmodule

// File: tb/pred_exec_stage_tb.sv
module pred_exec_stage_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [2:0]  in_cc = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [4:0]  in_shamt = '0;
    logic [3:0]  in_dst = '0;
    logic [31:0] res_data;
    logic [3:0]  res_dst;
    logic        res_wen;
    logic        br_taken;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_exec_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cc(in_cc), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
        .in_dst(in_dst), .res_data(res_data), .res_dst(res_dst),
        .res_wen(res_wen), .br_taken(br_taken)
    );

    typedef struct {
        bit          wen;
        bit          br;
        logic [31:0] data;
        logic [3:0]  dst;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          mfl = 0;        // bench flag model: 0 equal, 1 less, 2 greater
    logic [31:0] rf [16];
    bit          last_br = 0;
    bit          done = 0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_pass(int cc);
        case (cc)
            0: return 1;
            1: return mfl == 0;
            2: return mfl != 0;
            3: return mfl == 2;
            4: return mfl == 1;
            5: return mfl != 1;
            6: return mfl != 2;
            default: return 0;
        endcase
    endfunction

    task automatic drive_now(int op, int cc, logic [31:0] a, logic [31:0] b,
                             int sh, int dst, string tag);
        exp_t        e;
        logic [31:0] bs;
        bit          p;
        bs = b << sh;
        p  = m_pass(cc);
        in_valid = 1; in_op = 3'(op); in_cc = 3'(cc);
        in_a = a; in_b = b; in_shamt = 5'(sh); in_dst = 4'(dst);
        e.wen  = p && (op == 1 || op == 2);
        e.br   = p && op == 4;
        e.data = (op == 1) ? a + bs : a - bs;
        e.dst  = 4'(dst);
        e.tag  = tag;
        if (p && op == 3) mfl = (a == bs) ? 0 : (a < bs) ? 1 : 2;
        q.push_back(e);
    endtask

    task automatic issue(int op, int cc, logic [31:0] a, logic [31:0] b,
                         int sh, int dst, string tag);
        @(negedge clk);
        drive_now(op, cc, a, b, sh, dst, tag);
    endtask

    task automatic issue_rr(int op, int cc, int ra, int rb, int dst, string tag);
        @(negedge clk);
        drive_now(op, cc, rf[ra], rf[rb], 0, dst, tag);
    endtask

    task automatic idle(string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 0; in_op = 3'd1; in_cc = 3'd0; in_a = 32'h55; in_b = 32'h1;
        e.wen = 0; e.br = 0; e.data = '0; e.dst = '0; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic int gcd_ref(int a, int b);
        while (b != 0) begin
            int t;
            t = a % b; a = b; b = t;
        end
        return a;
    endfunction

    task automatic gcd_run(int a, int b);
        int it;
        issue(1, 0, 32'(a), 0, 0, 1, "R11 load");
        issue(1, 0, 32'(b), 0, 0, 2, "R11 load");
        it = 0;
        do begin
            issue_rr(3, 0, 1, 2, 0, "R11 cmp");
            issue_rr(2, 3, 1, 2, 1, "R11 subgt");
            issue_rr(2, 6, 2, 1, 2, "R11 suble");
            issue(4, 2, 0, 0, 0, 0, "R11 bne");
            idle("R11 gap");
            it++;
        end while (last_br && it < 400);
        idle("R11 drain");
        chk(rf[1] == 32'(gcd_ref(a, b)), "R11", "gcd", rf[1], 32'(gcd_ref(a, b)));
    endtask

    // Monitor: pops one expected item per clock after the edge.
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) e = q.pop_front();
            else begin
                e.wen = 0; e.br = 0; e.data = '0; e.dst = '0; e.tag = "R9 idle";
            end
            chk(res_wen == e.wen, e.tag, "res_wen", 32'(res_wen), 32'(e.wen));
            chk(br_taken == e.br, e.tag, "br_taken", 32'(br_taken), 32'(e.br));
            if (e.wen && res_wen) begin
                chk(res_data == e.data, e.tag, "res_data", res_data, e.data);
                chk(res_dst == e.dst, e.tag, "res_dst", 32'(res_dst), 32'(e.dst));
            end
            if (res_wen) rf[res_dst] = res_data;
            last_br = br_taken;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        chk(!res_wen && !br_taken, "R1", "outputs in reset", {30'd0, res_wen, br_taken}, 0);
        rst_n = 1;
        // R1: flags start equal, so an EQ-tagged add executes
        issue(1, 1, 32'd5, 32'd0, 0, 3, "R1 eq after reset");
        // R2/R3/R8: greater
        issue(3, 0, 32'd10, 32'd3, 0, 0, "R2 cmp gt");
        issue(2, 3, 32'd10, 32'd3, 0, 4, "R3 subgt");
        issue(2, 6, 32'd10, 32'd3, 0, 4, "R3 suble skip");
        issue(4, 2, 0, 0, 0, 0, "R8 bne taken");
        issue(4, 1, 0, 0, 0, 0, "R8 beq not");
        // less
        issue(3, 0, 32'd2, 32'd9, 0, 0, "R2 cmp lt");
        issue(2, 6, 32'd2, 32'd9, 0, 5, "R3 suble lt");
        issue(1, 5, 32'd1, 32'd1, 0, 5, "R3 ge skip");
        issue(1, 4, 32'd7, 32'd1, 0, 6, "R3 lt");
        // equal
        issue(3, 0, 32'd4, 32'd1, 2, 0, "R2 cmp eq shifted");
        issue(2, 6, 32'd4, 32'd1, 0, 6, "R3 suble eq");
        issue(4, 2, 0, 0, 0, 0, "R8 bne not");
        // unsigned compare
        issue(3, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, "R2 unsigned");
        issue(1, 3, 32'd1, 32'd1, 0, 7, "R2 gt after unsigned");
        // R5: failing compare keeps flags
        issue(3, 7, 32'd1, 32'd1, 0, 0, "R5 cmp nv");
        issue(3, 4, 32'd1, 32'd1, 0, 0, "R5 cmp lt false");
        issue(1, 3, 32'd2, 32'd2, 0, 8, "R5 flags kept gt");
        // R4
        issue(1, 7, 32'd2, 32'd2, 0, 8, "R4 nv");
        issue(2, 0, 32'd9, 32'd2, 0, 8, "R4 al");
        // R10: add/sub/branch keep flags
        issue(1, 0, 32'd0, 32'd0, 0, 9, "R10 add");
        issue(4, 0, 0, 0, 0, 0, "R10 bal");
        issue(1, 3, 32'd3, 32'd3, 0, 9, "R10 still gt");
        // R6/R7 shifts
        issue(1, 0, 32'd100, 32'd3, 4, 10, "R6 shift4");
        issue(1, 0, 32'd1, 32'd3, 31, 10, "R6 shift31");
        issue(1, 0, 32'hFFFF_FFFF, 32'd2, 0, 10, "R6 wrap");
        issue(2, 0, 32'd0, 32'd1, 0, 11, "R7 underflow");
        issue(2, 0, 32'd1000, 32'd5, 3, 12, "R7 shift3");
        // R9 idle with live inputs
        idle("R9 idle");
        idle("R9 idle");
        issue(0, 0, 32'd1, 32'd1, 0, 13, "R9 nop");
        issue(1, 3, 32'd4, 32'd4, 0, 13, "R9 flags held");
        // R11
        gcd_run(48, 18);
        gcd_run(7, 7);
        gcd_run(13, 5);
        gcd_run(1071, 462);
        repeat (3) idle("R9 tail");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule